// File: doc/BRIEF.md
# Expanded-Memory Page Pointer I/O Slave

This block is an 8-bit I/O slave for a legacy PC expansion bus. It holds four 16-bit page-frame pointers that a memory-mapping stage uses to translate accesses into a 16 KB page window. Each pointer is visible as two byte ports inside an eight-port I/O window. The even port of a pair holds the low byte and the odd port holds the high byte.

The slave watches the two I/O strobes, the two memory strobes and the address-enable line. All five signals pass through a synchroniser before the cycle is classified. On a read hit, the slave drives the selected byte and raises its bus output enable until the strobes go idle again. On a write hit, it merges the data byte into one half of the target pointer when the cycle ends. The full pointer set is always available as a flat parallel output.

Top module: `isa_page_regs`

## Requirements
- R1: After reset every pointer is zero and the bus output enable is low.
- R2: An I/O cycle is serviced only when the enable line reads low and exactly one I/O strobe is low with the other three strobes high. Any other mix is ignored: the bus is not driven and no pointer changes.
- R3: A cycle with a memory strobe low is never treated as I/O, whatever the enable line reads. It leaves the bus undriven and the pointers unchanged.
- R4: A port is in the window when address bits 11:3 equal the `BASE_SEL` parameter. Address bits 15:12 take no part in the decode, so every upper nibble aliases.
- R5: Offset (address bits 2:0) selects the byte. Bits 2:1 give the pointer index 0..3, bit 0 = 0 selects pointer bits 7:0, and bit 0 = 1 selects bits 15:8.
- R6: A byte write changes only the selected half of the selected pointer. The other half and the other pointers keep their values.
- R7: On a read hit, the output enable rises three clocks after the strobe falls and carries the selected byte. It stays high while the strobe is low and falls three clocks after the strobes are all high again.
- R8: Write data is taken from the data input in the clock in which the synchronised strobes are seen idle. The pointer output shows the new value three clocks after the strobe rises.
- R9: A read outside the window leaves the output enable low.
- R10: `page_ptrs` presents pointer n on bits 16n+15:16n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_aen | input | 1 | Address enable, high during DMA (I/O is ignored while high) |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_memr_n | input | 1 | Memory read strobe, active low |
| bus_memw_n | input | 1 | Memory write strobe, active low |
| bus_din | input | 8 | Data from bus |
| bus_dout | output | 8 | Data to bus, zero when not enabled |
| bus_dout_oe | output | 1 | Bus data output enable |
| page_ptrs | output | 64 | Four page pointers, pointer 0 in the low bits |

## Verification
Every result of this block is due a fixed number of clocks after a strobe edge. Two synchroniser flops plus the state register make the output enable and the read byte appear on the third rising edge after the strobe falls. The enable release and the pointer update land on the third rising edge after the strobe rises. The bench drives inputs on falling edges and counts exactly three rising edges before it samples at the next falling edge. It also samples once more two edges after release, to confirm that the enable is still held. The pointer state after every vector, including ignored cycles, is compared with a model that the bench builds from the requirements.

// File: rtl/isa_page_regs.sv
module isa_page_regs #(
  parameter logic [8:0] BASE_SEL    = 9'h0D0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_aen,
  input  logic        bus_ior_n,
  input  logic        bus_iow_n,
  input  logic        bus_memr_n,
  input  logic        bus_memw_n,
  input  logic [7:0]  bus_din,
  output logic [7:0]  bus_dout,
  output logic        bus_dout_oe,
  output logic [63:0] page_ptrs
);
  localparam int NPTR = 4;
  localparam int PW   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_SKIP} st_t;

  // {aen, memw_n, memr_n, iow_n, ior_n}
  logic [4:0]    sync_q [SYNC_STAGES];
  logic [4:0]    s;
  logic          strb_idle;
  st_t           state_q;
  logic [2:0]    off_q;
  logic          hit_q;
  logic [7:0]    rd_q;
  logic [PW-1:0] ptr_q [NPTR];
  logic          in_win;
  logic [7:0]    sel_byte;
  logic          unused_hi;

  assign unused_hi = ^bus_addr[15:12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '1;
    else        sync_q[0] <= {bus_aen, bus_memw_n, bus_memr_n, bus_iow_n, bus_ior_n};
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign s         = sync_q[SYNC_STAGES-1];
  assign strb_idle = &s[3:0];
  assign in_win    = (bus_addr[11:3] == BASE_SEL);
  assign sel_byte  = bus_addr[0] ? ptr_q[bus_addr[2:1]][15:8] : ptr_q[bus_addr[2:1]][7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      off_q       <= '0;
      hit_q       <= 1'b0;
      rd_q        <= '0;
      bus_dout_oe <= 1'b0;
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (!strb_idle) begin
          off_q <= bus_addr[2:0];
          hit_q <= in_win;
          rd_q  <= sel_byte;
          if (!s[4] && s[3:0] == 4'b1110) begin
            state_q     <= ST_READ;
            bus_dout_oe <= in_win;
          end else if (!s[4] && s[3:0] == 4'b1101) begin
            state_q <= ST_WRITE;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_WRITE: if (strb_idle) begin
          state_q <= ST_IDLE;
          if (hit_q) begin
            if (off_q[0]) ptr_q[off_q[2:1]][15:8] <= bus_din;
            else          ptr_q[off_q[2:1]][7:0]  <= bus_din;
          end
        end
        default: if (strb_idle) begin
          state_q     <= ST_IDLE;
          bus_dout_oe <= 1'b0;
        end
      endcase
    end
  end

  assign bus_dout = bus_dout_oe ? rd_q : 8'h00;

  generate
    for (genvar p = 0; p < NPTR; p++) begin : g_out
      assign page_ptrs[p*PW +: PW] = ptr_q[p];
    end
  endgenerate

  assert_no_drive_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |-> !bus_dout_oe);

  assert_no_drive_on_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !bus_dout_oe);

  assert_ptrs_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_WRITE) |=> $stable(page_ptrs));

  assert_one_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |=> ($countones(page_ptrs ^ $past(page_ptrs)) <= 8));

  assert_oe_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dout_oe && !strb_idle) |=> bus_dout_oe);
endmodule

// File: tb/test_isa_page_regs.sv
module test_isa_page_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_aen = 1'b1;
  logic        bus_ior_n = 1'b1, bus_iow_n = 1'b1, bus_memr_n = 1'b1, bus_memw_n = 1'b1;
  logic [7:0]  bus_din = '0;
  logic [7:0]  bus_dout;
  logic        bus_dout_oe;
  logic [63:0] page_ptrs;

  int tests = 0;
  int fails = 0;
  logic [15:0] m [4];

  always #4 clk = ~clk;

  isa_page_regs i_isa_page_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_memr_n(bus_memr_n),
    .bus_memw_n(bus_memw_n), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .page_ptrs(page_ptrs)
  );

  // strobe order {memw_n, memr_n, iow_n, ior_n}
  typedef struct packed {
    logic [3:0]  strb;
    logic        aen;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        exp_oe;
    logic [7:0]  exp_data;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'b1101, 1'b0, 16'h0680, 8'h11, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0681, 8'h22, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0682, 8'h33, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0683, 8'h44, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0684, 8'h55, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0685, 8'h66, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0686, 8'h77, 1'b0, 8'h00},
    '{4'b1101, 1'b0, 16'h0687, 8'h88, 1'b0, 8'h00},
    '{4'b1110, 1'b0, 16'h0680, 8'h00, 1'b1, 8'h11},
    '{4'b1110, 1'b0, 16'h0687, 8'h00, 1'b1, 8'h88},
    '{4'b1110, 1'b0, 16'hF683, 8'h00, 1'b1, 8'h44},
    '{4'b1101, 1'b0, 16'h9684, 8'hA5, 1'b0, 8'h00},
    '{4'b1110, 1'b0, 16'h0685, 8'h00, 1'b1, 8'h66},
    '{4'b1110, 1'b0, 16'h0684, 8'h00, 1'b1, 8'hA5},
    '{4'b1110, 1'b0, 16'h0688, 8'h00, 1'b0, 8'h00},
    '{4'b1110, 1'b0, 16'h067F, 8'h00, 1'b0, 8'h00},
    '{4'b1101, 1'b1, 16'h0681, 8'hEE, 1'b0, 8'h00},
    '{4'b1110, 1'b1, 16'h0681, 8'h00, 1'b0, 8'h00},
    '{4'b1110, 1'b0, 16'h0681, 8'h00, 1'b1, 8'h22}
  };

  function automatic logic [63:0] model_flat();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Applies one bus cycle; returns enable/data mid-cycle, enable two clocks
  // after release and enable three clocks after release.
  task automatic bus_cycle(input logic [3:0] strb, input logic aen, input logic [15:0] a,
                           input logic [7:0] d, output logic oe_mid, output logic [7:0] do_mid,
                           output logic oe_hold, output logic oe_end);
    @(negedge clk);
    bus_addr = a; bus_din = d; bus_aen = aen;
    {bus_memw_n, bus_memr_n, bus_iow_n, bus_ior_n} = strb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe_mid = bus_dout_oe; do_mid = bus_dout;
    @(posedge clk);
    @(negedge clk);
    {bus_memw_n, bus_memr_n, bus_iow_n, bus_ior_n} = 4'b1111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    oe_hold = bus_dout_oe;
    @(posedge clk);
    @(negedge clk);
    oe_end = bus_dout_oe;
    bus_aen = 1'b1;
    @(posedge clk);
  endtask

  // Model of a write per R2, R4, R5, R6
  task automatic model_apply(input logic [3:0] strb, input logic aen, input logic [15:0] a,
                             input logic [7:0] d);
    if (strb == 4'b1101 && !aen && a[11:3] == 9'h0D0) begin
      if (a[0]) m[a[2:1]][15:8] = d;
      else      m[a[2:1]][7:0]  = d;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic oe_mid, oe_hold, oe_end;
    logic [7:0] do_mid;
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(page_ptrs == 64'h0, "R1", "pointers after reset", page_ptrs, 64'h0);
    check(bus_dout_oe == 1'b0, "R1", "enable after reset", {63'h0, bus_dout_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NV; v++) begin
      bus_cycle(VEC[v].strb, VEC[v].aen, VEC[v].addr, VEC[v].data, oe_mid, do_mid, oe_hold, oe_end);
      model_apply(VEC[v].strb, VEC[v].aen, VEC[v].addr, VEC[v].data);
      check(oe_mid == VEC[v].exp_oe, "R7/R9/R2", $sformatf("vec %0d enable", v),
            {63'h0, oe_mid}, {63'h0, VEC[v].exp_oe});
      if (VEC[v].exp_oe) begin
        check(do_mid == VEC[v].exp_data, "R5/R4", $sformatf("vec %0d read byte", v),
              {56'h0, do_mid}, {56'h0, VEC[v].exp_data});
        check(oe_hold == 1'b1, "R7", $sformatf("vec %0d enable held", v),
              {63'h0, oe_hold}, 64'h1);
      end
      check(oe_end == 1'b0, "R7", $sformatf("vec %0d enable released", v),
            {63'h0, oe_end}, 64'h0);
      check(page_ptrs == model_flat(), "R6/R8/R10", $sformatf("vec %0d pointers", v),
            page_ptrs, model_flat());
    end

    // R3: memory write aimed at a window address, enable line low
    bus_cycle(4'b0111, 1'b0, 16'h0680, 8'hFF, oe_mid, do_mid, oe_hold, oe_end);
    check(page_ptrs == model_flat(), "R3", "mem write ignored", page_ptrs, model_flat());
    // R3: memory read with enable line high, then with I/O read also low
    bus_cycle(4'b1011, 1'b1, 16'h0680, 8'h00, oe_mid, do_mid, oe_hold, oe_end);
    check(oe_mid == 1'b0, "R3", "mem read no drive", {63'h0, oe_mid}, 64'h0);
    bus_cycle(4'b1010, 1'b0, 16'h0680, 8'h00, oe_mid, do_mid, oe_hold, oe_end);
    check(oe_mid == 1'b0, "R3", "mem+io read no drive", {63'h0, oe_mid}, 64'h0);
    // R2: both I/O strobes low
    bus_cycle(4'b1100, 1'b0, 16'h0682, 8'h99, oe_mid, do_mid, oe_hold, oe_end);
    check(oe_mid == 1'b0, "R2", "dual io no drive", {63'h0, oe_mid}, 64'h0);
    check(page_ptrs == model_flat(), "R2", "dual io no write", page_ptrs, model_flat());
    // R8: data changes during the strobe; the value at release is kept
    @(negedge clk);
    bus_addr = 16'h0686; bus_din = 8'h01; bus_aen = 1'b0; bus_iow_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    bus_din = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    bus_iow_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(page_ptrs[55:48] == 8'h77, "R8", "not yet written", {56'h0, page_ptrs[55:48]}, 64'h77);
    @(posedge clk);
    @(negedge clk);
    m[3][7:0] = 8'hC3;
    check(page_ptrs == model_flat(), "R8", "late data captured", page_ptrs, model_flat());
    bus_aen = 1'b1;
    // R1: reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check(page_ptrs == 64'h0, "R1", "pointers after second reset", page_ptrs, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule